// File: doc/BRIEF.md
# Multi-Rate 8b/10b Serial Word Formatter

This block sits between a frame scheduler and a fixed-speed serializer. On every core clock cycle, it hands the serializer one 30-bit parallel word. The serializer shifts each word out at a constant bit-slot rate. The scheduler supplies three byte lanes, a control/data flag for each lane, and a shared valid strobe. The block encodes each lane into a 10-bit 8b/10b symbol, in lane order 0, 1, 2. It carries the running disparity from one symbol to the next, across lanes and across cycles.

The line rate is chosen without touching the serializer. At full rate, all 30 slots carry distinct encoded bits. At half rate, every encoded bit fills two adjacent slots, so a captured group of three symbols drains over two cycles. At third rate, every encoded bit fills three adjacent slots and the group drains over three cycles. A single-lane mode encodes only lane 0 on each valid cycle and spreads that one symbol over a whole word at third rate. A bypass input substitutes a raw 30-bit stream for the encoded one. The raw stream is then spread according to the same rate rules.

Top module: `serial_word_formatter`

## Requirements
- R1: While `rst_n` is low and after it is released, with no valid strobe, `ser_word` is all zeros. The running disparity starts negative, so a first K28.5 on lane 0 yields a..j = 0011111010, which reads 10'h17C on `ser_word[9:0]`.
- R2: At full rate (`rate_sel` 0, or the unused code 3), a valid cycle is followed by a word on the next cycle. That word carries lane 0's symbol in bits 9:0, lane 1's in bits 19:10 and lane 2's in bits 29:20. Within each symbol, bit a sits at the lowest index and is shifted out first.
- R3: Running disparity flips after every unbalanced symbol. It is passed from lane 0 to lane 1 to lane 2 within a cycle, and on to the next valid cycle.
- R4: At half rate (`rate_sel` 1), the 30-bit encoded stream S is captured on valid. The first cycle after capture carries S[i] in word bits 2i and 2i+1. The second cycle carries S[15+i] there.
- R5: At third rate (`rate_sel` 2), the captured stream drains over three cycles. In cycle c, word bits 3i, 3i+1 and 3i+2 all carry S[10c+i].
- R6: With `single_lane` high, `rate_sel` is overridden. Each valid cycle encodes only lane 0, and the next word holds its symbol bit i in bits 3i..3i+2. Lanes 1 and 2 and their flags have no effect, and disparity advances by one symbol only.
- R7: On cycles without valid, the phase steps on and wraps after the last phase of the current rate. The captured stream is therefore resent cyclically; at full rate, the same word repeats.
- R8: A valid strobe always restarts at phase 0 with the new stream, even in the middle of a slower-rate sequence.
- R9: With `bypass_en` high on a valid cycle, `raw_word` (bit 0 first) replaces the encoded stream under the same rate rules. In single-lane mode, only `raw_word[9:0]` is used. Running disparity is left unchanged.
- R10: Data bytes use the standard 5b/6b and 3b/4b code tables, including the alternate x.7 form. A flagged byte with value 8'hBC, or any K28.y, yields the standard K28.y control symbol, and in positive disparity the whole symbol is the bitwise complement of its negative-disparity form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, one word per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | 0 full, 1 half, 2 third, 3 treated as full |
| single_lane | input | 1 | Encode lane 0 only, fixed third rate |
| bypass_en | input | 1 | Use raw_word instead of encoded symbols |
| valid | input | 1 | Capture strobe for the lane inputs |
| lane_byte | input | 24 | Byte lanes; lane n in bits 8n+7:8n |
| lane_is_k | input | 3 | Control flag for each lane |
| raw_word | input | 30 | Raw stream for bypass, bit 0 first |
| ser_word | output | 30 | Parallel word to the serializer |

## Verification
The assertions check three structural properties on every cycle. At half rate, slots come in equal pairs; at third rate and in single-lane mode, they come in equal triples. Every encoded full-rate symbol has four to six ones. The phase always stays within its rate's range and returns to zero after each valid. The bench's scenarios are needed to show the actual code values, which lane lands where, how disparity moves across lanes and cycles, that single-lane ignores lanes 1 and 2, and that bypass leaves the disparity alone. All of these need an independent encoding model to compare against.

// File: rtl/swf_pkg.sv
package swf_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SYM_W  = 10;

    typedef enum logic [1:0] {
        FMT_FULL   = 2'd0,
        FMT_HALF   = 2'd1,
        FMT_THIRD  = 2'd2,
        FMT_SINGLE = 2'd3
    } fmt_e;

    // cycles a captured stream occupies before it wraps
    function automatic int unsigned fmt_span(input fmt_e f);
        case (f)
            FMT_HALF:  return 2;
            FMT_THIRD: return 3;
            default:   return 1;
        endcase
    endfunction

    // number of adjacent slots each stream bit fills
    function automatic int unsigned fmt_rep(input fmt_e f);
        case (f)
            FMT_HALF:   return 2;
            FMT_THIRD:  return 3;
            FMT_SINGLE: return 3;
            default:    return 1;
        endcase
    endfunction

endpackage

// File: rtl/swf_sym_encoder.sv
module swf_sym_encoder
    import swf_pkg::*;
(
    input  logic [BYTE_W-1:0] data,
    input  logic              is_k,
    input  logic              rd_in,
    output logic [SYM_W-1:0]  sym,
    output logic              rd_out
);

    // 5b/6b code, negative-disparity form, MSB = a
    function automatic logic [5:0] tab6(input logic [4:0] x);
        case (x)
            5'd0:  return 6'b100111;
            5'd1:  return 6'b011101;
            5'd2:  return 6'b101101;
            5'd3:  return 6'b110001;
            5'd4:  return 6'b110101;
            5'd5:  return 6'b101001;
            5'd6:  return 6'b011001;
            5'd7:  return 6'b111000;
            5'd8:  return 6'b111001;
            5'd9:  return 6'b100101;
            5'd10: return 6'b010101;
            5'd11: return 6'b110100;
            5'd12: return 6'b001101;
            5'd13: return 6'b101100;
            5'd14: return 6'b011100;
            5'd15: return 6'b010111;
            5'd16: return 6'b011011;
            5'd17: return 6'b100011;
            5'd18: return 6'b010011;
            5'd19: return 6'b110010;
            5'd20: return 6'b001011;
            5'd21: return 6'b101010;
            5'd22: return 6'b011010;
            5'd23: return 6'b111010;
            5'd24: return 6'b110011;
            5'd25: return 6'b100110;
            5'd26: return 6'b010110;
            5'd27: return 6'b110110;
            5'd28: return 6'b001110;
            5'd29: return 6'b101110;
            5'd30: return 6'b011110;
            default: return 6'b101011;
        endcase
    endfunction

    // 3b/4b code, negative-disparity form, MSB = f
    function automatic logic [3:0] tab4(input logic [2:0] y, input logic alt);
        case (y)
            3'd0: return 4'b1011;
            3'd1: return 4'b1001;
            3'd2: return 4'b0101;
            3'd3: return 4'b1100;
            3'd4: return 4'b1101;
            3'd5: return 4'b1010;
            3'd6: return 4'b0110;
            default: return alt ? 4'b0111 : 4'b1110;
        endcase
    endfunction

    logic [4:0] x;
    logic [2:0] y;
    logic       k28;
    logic [5:0] c6_base, c6;
    logic [3:0] c4_base, c4;
    logic       bal6, bal4, rd_mid, alt7;

    always_comb begin
        x       = data[4:0];
        y       = data[7:5];
        k28     = is_k && (x == 5'd28);
        c6_base = k28 ? 6'b001111 : tab6(x);
        bal6    = ($countones(c6_base) == 3);
        c6      = (rd_in && (!bal6 || c6_base == 6'b111000)) ? ~c6_base : c6_base;
        rd_mid  = bal6 ? rd_in : ~rd_in;

        alt7 = (y == 3'd7) &&
               (is_k ||
                (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
        c4_base = tab4(y, alt7);
        bal4    = ($countones(c4_base) == 2);
        if (rd_mid && (!bal4 || c4_base == 4'b1100))
            c4 = ~c4_base;
        else if (k28 && !rd_mid && bal4 && c4_base != 4'b1100)
            c4 = ~c4_base;
        else
            c4 = c4_base;
        rd_out = bal4 ? rd_mid : ~rd_mid;

        // bit a first on the line -> lowest index
        for (int i = 0; i < 6; i++) sym[i]     = c6[5-i];
        for (int i = 0; i < 4; i++) sym[6 + i] = c4[3-i];
    end

endmodule

// File: rtl/swf_word_replicator.sv
module swf_word_replicator
    import swf_pkg::*;
#(
    parameter int unsigned W      = 30,
    parameter int unsigned MAXREP = 3,
    localparam int unsigned PH_W  = (MAXREP > 1) ? $clog2(MAXREP) : 1,
    localparam int unsigned SEL_W = (MAXREP > 1) ? $clog2(MAXREP) : 1
) (
    input  logic [W-1:0]    stream,
    input  fmt_e            fmt,
    input  logic [PH_W-1:0] phase,
    output logic [W-1:0]    word
);

    logic [MAXREP-1:0][W-1:0] cand;

    for (genvar r = 1; r <= MAXREP; r++) begin : g_rep
        logic [W-1:0] w_r;
        always_comb begin
            for (int j = 0; j < W; j++) begin
                int idx;
                idx    = int'(phase) * int'(W / r) + j / r;
                w_r[j] = (idx < int'(W)) ? stream[idx] : 1'b0;
            end
        end
        assign cand[r-1] = w_r;
    end

    logic [SEL_W-1:0] sel;
    always_comb begin
        sel  = SEL_W'(fmt_rep(fmt) - 1);
        word = cand[sel];
    end

endmodule

// File: rtl/serial_word_formatter.sv
module serial_word_formatter
    import swf_pkg::*;
#(
    parameter int unsigned LANES  = 3,
    localparam int unsigned WORD_W = LANES * SYM_W,
    localparam int unsigned PH_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               rate_sel,
    input  logic                     single_lane,
    input  logic                     bypass_en,
    input  logic                     valid,
    input  logic [LANES*BYTE_W-1:0]  lane_byte,
    input  logic [LANES-1:0]         lane_is_k,
    input  logic [WORD_W-1:0]        raw_word,
    output logic [WORD_W-1:0]        ser_word
);

    typedef struct packed {
        logic [WORD_W-1:0] stream;
        fmt_e              fmt;
        logic [PH_W-1:0]   phase;
        logic              rd;
        logic              raw;
    } state_t;

    localparam state_t RST_ST = '{stream: '0, fmt: FMT_FULL, phase: '0, rd: 1'b0, raw: 1'b1};

    state_t q, d;

    // encoder chain: disparity ripples lane 0 -> lane LANES-1
    logic [LANES:0]   rd_c;
    logic [SYM_W-1:0] sym [LANES];

    assign rd_c[0] = q.rd;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        swf_sym_encoder u_enc (
            .data   (lane_byte[i*BYTE_W +: BYTE_W]),
            .is_k   (lane_is_k[i]),
            .rd_in  (rd_c[i]),
            .sym    (sym[i]),
            .rd_out (rd_c[i+1])
        );
    end

    fmt_e fmt_in;

    always_comb begin
        d = q;
        if (single_lane)          fmt_in = FMT_SINGLE;
        else if (rate_sel == 2'd1) fmt_in = FMT_HALF;
        else if (rate_sel == 2'd2) fmt_in = FMT_THIRD;
        else                       fmt_in = FMT_FULL;

        if (valid) begin
            d.fmt   = fmt_in;
            d.phase = '0;
            d.raw   = bypass_en;
            if (bypass_en) begin
                d.stream = raw_word;
            end else if (single_lane) begin
                d.stream            = '0;
                d.stream[SYM_W-1:0] = sym[0];
                d.rd                = rd_c[1];
            end else begin
                for (int i = 0; i < LANES; i++)
                    d.stream[i*SYM_W +: SYM_W] = sym[i];
                d.rd = rd_c[LANES];
            end
        end else begin
            if (int'(q.phase) + 1 >= int'(fmt_span(q.fmt)))
                d.phase = '0;
            else
                d.phase = q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_ST;
        else        q <= d;
    end

    swf_word_replicator #(
        .W      (WORD_W),
        .MAXREP (LANES)
    ) u_rep (
        .stream (q.stream),
        .fmt    (q.fmt),
        .phase  (q.phase),
        .word   (ser_word)
    );

    // state views for the bound checker
    logic [1:0]      st_fmt;
    logic [PH_W-1:0] st_phase;
    logic            st_raw;
    assign st_fmt   = q.fmt;
    assign st_phase = q.phase;
    assign st_raw   = q.raw;

endmodule

// File: rtl/swf_formatter_chk.sv
module swf_formatter_chk #(
    parameter int unsigned W    = 30,
    parameter int unsigned PH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            valid,
    input logic [W-1:0]    word,
    input logic [1:0]      fmt,
    input logic [PH_W-1:0] phase,
    input logic            raw
);

    function automatic logic pairs_ok(input logic [W-1:0] w);
        for (int i = 0; i < int'(W / 2); i++)
            if (w[2*i] != w[2*i+1]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic triples_ok(input logic [W-1:0] w);
        for (int i = 0; i < int'(W / 3); i++)
            if (w[3*i] != w[3*i+1] || w[3*i] != w[3*i+2]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic balance_ok(input logic [W-1:0] w);
        for (int s = 0; s < int'(W / 10); s++) begin
            int n;
            n = 0;
            for (int b = 0; b < 10; b++) n += int'(w[s*10 + b]);
            if (n < 4 || n > 6) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic int span_of(input logic [1:0] f);
        return (f == 2'd1) ? 2 : ((f == 2'd2) ? 3 : 1);
    endfunction

    a_r4_half_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == 2'd1) |-> pairs_ok(word));

    a_r5_third_triples: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == 2'd2) |-> triples_ok(word));

    a_r6_single_triples: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == 2'd3) |-> triples_ok(word));

    a_r3_full_balanced: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == 2'd0 && !raw) |-> balance_ok(word));

    a_r7_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase) < span_of(fmt));

    a_r7_half_phase_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && fmt == 2'd1) |=> (phase != $past(phase)));

    a_r8_valid_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> (phase == '0));

endmodule

bind serial_word_formatter swf_formatter_chk #(
    .W    (WORD_W),
    .PH_W (PH_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (valid),
    .word  (ser_word),
    .fmt   (st_fmt),
    .phase (st_phase),
    .raw   (st_raw)
);

// File: tb/tb_serial_word_formatter.sv
`timescale 1ns/1ps
module tb_serial_word_formatter;

    localparam int CLK_PERIOD = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic        single_lane = 1'b0;
    logic        bypass_en = 1'b0;
    logic        valid = 1'b0;
    logic [23:0] lane_byte = '0;
    logic [2:0]  lane_is_k = '0;
    logic [29:0] raw_word = '0;
    logic [29:0] ser_word;

    int n_chk = 0;
    int n_bad = 0;
    logic m_rd = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_word_formatter dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .single_lane(single_lane),
        .bypass_en(bypass_en), .valid(valid), .lane_byte(lane_byte),
        .lane_is_k(lane_is_k), .raw_word(raw_word), .ser_word(ser_word)
    );

    // reference 5b/6b: {neg form, pos form}, MSB = a
    function automatic logic [11:0] ref6(input logic [4:0] x);
        case (x)
            5'd0:  return {6'b100111, 6'b011000};
            5'd1:  return {6'b011101, 6'b100010};
            5'd2:  return {6'b101101, 6'b010010};
            5'd3:  return {6'b110001, 6'b110001};
            5'd4:  return {6'b110101, 6'b001010};
            5'd5:  return {6'b101001, 6'b101001};
            5'd6:  return {6'b011001, 6'b011001};
            5'd7:  return {6'b111000, 6'b000111};
            5'd8:  return {6'b111001, 6'b000110};
            5'd9:  return {6'b100101, 6'b100101};
            5'd10: return {6'b010101, 6'b010101};
            5'd11: return {6'b110100, 6'b110100};
            5'd12: return {6'b001101, 6'b001101};
            5'd13: return {6'b101100, 6'b101100};
            5'd14: return {6'b011100, 6'b011100};
            5'd15: return {6'b010111, 6'b101000};
            5'd16: return {6'b011011, 6'b100100};
            5'd17: return {6'b100011, 6'b100011};
            5'd18: return {6'b010011, 6'b010011};
            5'd19: return {6'b110010, 6'b110010};
            5'd20: return {6'b001011, 6'b001011};
            5'd21: return {6'b101010, 6'b101010};
            5'd22: return {6'b011010, 6'b011010};
            5'd23: return {6'b111010, 6'b000101};
            5'd24: return {6'b110011, 6'b001100};
            5'd25: return {6'b100110, 6'b100110};
            5'd26: return {6'b010110, 6'b010110};
            5'd27: return {6'b110110, 6'b001001};
            5'd28: return {6'b001110, 6'b001110};
            5'd29: return {6'b101110, 6'b010001};
            5'd30: return {6'b011110, 6'b100001};
            default: return {6'b101011, 6'b010100};
        endcase
    endfunction

    function automatic logic [7:0] ref4(input logic [2:0] y, input logic alt);
        case (y)
            3'd0: return {4'b1011, 4'b0100};
            3'd1: return {4'b1001, 4'b1001};
            3'd2: return {4'b0101, 4'b0101};
            3'd3: return {4'b1100, 4'b0011};
            3'd4: return {4'b1101, 4'b0010};
            3'd5: return {4'b1010, 4'b1010};
            3'd6: return {4'b0110, 4'b0110};
            default: return alt ? {4'b0111, 4'b1000} : {4'b1110, 4'b0001};
        endcase
    endfunction

    function automatic logic [3:0] refk28(input logic [2:0] y);
        case (y)
            3'd0: return 4'b0100;
            3'd1: return 4'b1001;
            3'd2: return 4'b0101;
            3'd3: return 4'b0011;
            3'd4: return 4'b0010;
            3'd5: return 4'b1010;
            3'd6: return 4'b0110;
            default: return 4'b1000;
        endcase
    endfunction

    // returns the symbol with bit a at index 0; advances m_rd
    function automatic logic [9:0] ref_sym(input logic [7:0] b, input logic k);
        logic [9:0]  v, s;
        logic [11:0] t6;
        logic [7:0]  t4;
        logic [5:0]  c6;
        logic        rdm, alt;
        if (k) begin
            v = {6'b001111, refk28(b[7:5])};
            if (m_rd) v = ~v;
        end else begin
            t6  = ref6(b[4:0]);
            c6  = m_rd ? t6[5:0] : t6[11:6];
            rdm = ($countones(c6) != 3) ? ~m_rd : m_rd;
            alt = (b[7:5] == 3'd7) &&
                  ((!rdm && (b[4:0] == 5'd17 || b[4:0] == 5'd18 || b[4:0] == 5'd20)) ||
                   ( rdm && (b[4:0] == 5'd11 || b[4:0] == 5'd13 || b[4:0] == 5'd14)));
            t4  = ref4(b[7:5], alt);
            v   = {c6, rdm ? t4[3:0] : t4[7:4]};
        end
        if ($countones(v) != 5) m_rd = ~m_rd;
        for (int i = 0; i < 10; i++) s[i] = v[9-i];
        return s;
    endfunction

    function automatic logic [29:0] ref_word(input logic [29:0] s, input int rep, input int ph);
        logic [29:0] w;
        for (int j = 0; j < 30; j++) w[j] = s[ph*(30/rep) + j/rep];
        return w;
    endfunction

    task automatic chk(input logic [29:0] got, input logic [29:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // call at a falling edge; drives one valid cycle and checks ncyc words
    task automatic send(input logic [23:0] b, input logic [2:0] k, input logic [1:0] r,
                        input logic sl, input logic bp, input logic [29:0] rw,
                        input int ncyc, input string tag);
        int span, rep;
        logic [29:0] s;
        span = sl ? 1 : ((r == 2'd1) ? 2 : ((r == 2'd2) ? 3 : 1));
        rep  = sl ? 3 : span;
        valid = 1'b1; lane_byte = b; lane_is_k = k; rate_sel = r;
        single_lane = sl; bypass_en = bp; raw_word = rw;
        s = '0;
        if (bp) s = rw;
        else begin
            s[9:0] = ref_sym(b[7:0], k[0]);
            if (!sl) begin
                s[19:10] = ref_sym(b[15:8], k[1]);
                s[29:20] = ref_sym(b[23:16], k[2]);
            end
        end
        for (int p = 0; p < ncyc; p++) begin
            @(negedge clk);
            if (p == 0) valid = 1'b0;
            chk(ser_word, ref_word(s, rep, p % span), tag);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ser_word, '0, "R1 word in reset");
        rst_n = 1'b1;
        m_rd = 1'b0;
        @(negedge clk);
        chk(ser_word, '0, "R1 word after reset");
        send({8'hBC, 8'hBC, 8'hBC}, 3'b111, 2'd0, 1'b0, 1'b0, '0, 1, "R1 R10 K28.5 from reset");
        chk({20'd0, ser_word[9:0]}, {20'd0, 10'h17C}, "R1 negative start disparity");
    endtask

    task automatic t_full();
        send({8'h4A, 8'h00, 8'hFF}, 3'b000, 2'd0, 1'b0, 1'b0, '0, 1, "R2 full data");
        send({8'h07, 8'h55, 8'hF1}, 3'b000, 2'd0, 1'b0, 1'b0, '0, 1, "R2 R3 full data");
        send({8'h3C, 8'hBC, 8'h1C}, 3'b110, 2'd3, 1'b0, 1'b0, '0, 1, "R2 code 3 as full");
    endtask

    task automatic t_codes();
        for (int i = 0; i < 256; i += 3) begin
            logic [7:0] b0, b1, b2;
            b0 = 8'(i); b1 = 8'(i + 1); b2 = 8'(i + 2);
            send({b2, b1, b0}, 3'b000, 2'd0, 1'b0, 1'b0, '0, 1, "R10 R3 data sweep");
        end
        for (int y = 0; y < 8; y++) begin
            logic [7:0] kb;
            kb = {3'(y), 5'd28};
            send({kb, 8'hF1, kb}, 3'b101, 2'd0, 1'b0, 1'b0, '0, 1, "R10 K28.y");
        end
        send({8'hEB, 8'hF4, 8'hEE}, 3'b000, 2'd0, 1'b0, 1'b0, '0, 1, "R10 alternate x.7");
        send({8'hF1, 8'hF2, 8'hED}, 3'b000, 2'd0, 1'b0, 1'b0, '0, 1, "R10 alternate x.7");
    endtask

    task automatic t_half();
        send({8'h12, 8'h34, 8'h56}, 3'b000, 2'd1, 1'b0, 1'b0, '0, 2, "R4 half rate");
        send({8'hBC, 8'h9A, 8'hBC}, 3'b101, 2'd1, 1'b0, 1'b0, '0, 2, "R4 half rate");
    endtask

    task automatic t_third();
        send({8'hC3, 8'h0F, 8'h81}, 3'b000, 2'd2, 1'b0, 1'b0, '0, 3, "R5 third rate");
        send({8'hBC, 8'hBC, 8'h66}, 3'b110, 2'd2, 1'b0, 1'b0, '0, 3, "R5 third rate");
    endtask

    task automatic t_single();
        send({8'h11, 8'h22, 8'hBC}, 3'b001, 2'd0, 1'b1, 1'b0, '0, 1, "R6 single lane");
        send({8'hFF, 8'hBC, 8'h5A}, 3'b110, 2'd1, 1'b1, 1'b0, '0, 1, "R6 lanes 1-2 ignored");
        send({8'h00, 8'h00, 8'h5A}, 3'b000, 2'd2, 1'b1, 1'b0, '0, 1, "R6 every cycle");
        send({8'hA5, 8'h3C, 8'h83}, 3'b000, 2'd0, 1'b1, 1'b0, '0, 1, "R6 every cycle");
        send({8'h10, 8'h20, 8'h30}, 3'b000, 2'd0, 1'b0, 1'b0, '0, 1, "R6 R3 disparity after single");
    endtask

    task automatic t_hold();
        send({8'h21, 8'h43, 8'h65}, 3'b000, 2'd0, 1'b0, 1'b0, '0, 3, "R7 full repeat");
        send({8'h87, 8'hA9, 8'hCB}, 3'b000, 2'd1, 1'b0, 1'b0, '0, 5, "R7 half wrap");
        send({8'hED, 8'h0F, 8'h21}, 3'b000, 2'd2, 1'b0, 1'b0, '0, 4, "R7 third wrap");
    endtask

    task automatic t_restart();
        send({8'h01, 8'h02, 8'h03}, 3'b000, 2'd2, 1'b0, 1'b0, '0, 1, "R8 first");
        send({8'h04, 8'h05, 8'h06}, 3'b000, 2'd2, 1'b0, 1'b0, '0, 2, "R8 restart mid third");
        send({8'h07, 8'h08, 8'h09}, 3'b000, 2'd1, 1'b0, 1'b0, '0, 1, "R8 first half");
        send({8'h0A, 8'h0B, 8'h0C}, 3'b000, 2'd1, 1'b0, 1'b0, '0, 2, "R8 restart mid half");
    endtask

    task automatic t_bypass();
        send('0, '0, 2'd0, 1'b0, 1'b1, 30'h2AAA_5555, 1, "R9 bypass full");
        send('0, '0, 2'd1, 1'b0, 1'b1, 30'h0F0F_3C3C, 2, "R9 bypass half");
        send('0, '0, 2'd2, 1'b0, 1'b1, 30'h3FF0_0CA5, 3, "R9 bypass third");
        send('0, '0, 2'd0, 1'b1, 1'b1, 30'h3FFF_FD5A, 1, "R9 bypass single");
        send({8'h00, 8'h00, 8'h00}, 3'b000, 2'd0, 1'b0, 1'b0, '0, 1, "R9 disparity kept");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_full();
        t_half();
        t_third();
        t_single();
        t_hold();
        t_restart();
        t_bypass();
        t_codes();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule